// File: doc/BRIEF.md
# Two-Bank Operand Fetch with Reuse Buffers

This block gathers the three source operands of a fused multiply-add style instruction. The operands come from a register file that is split into two banks by the parity of the register index. Each bank can serve one read per cycle. When several operands that still need a bank read fall into the same bank, the block spreads those reads over extra cycles. While it does so, it holds the issue side off. The all-ones register index is a hard-wired zero and never touches a bank.

Each of the three operand slots has a one-entry reuse buffer. When an instruction sets the keep flag for a slot, the value delivered in that slot is kept. If the next accepted instruction names the same register in the same slot, it takes the value from the buffer and uses no bank read. A write-back to a kept register drops the entry, so a stale value is never handed out.

An upstream issue stage presents an instruction with a valid/ready handshake. One cycle after the last bank read, the three operand values appear for one cycle with a valid pulse.

Top module: `operand_fetch`

## Requirements
- R1: After reset, issue ready is high, operand valid and stall are low, every register reads as zero and every reuse entry is empty.
- R2: The bank of a register is bit 0 of its index. The latency L equals the larger of the two per-bank counts of slots that need a bank read, with a minimum of 1. Operand valid pulses for one cycle, L cycles after the accepting clock edge, and the three values appear with it.
- R3: When L is greater than 1, issue ready is low and stall is high for the L-1 cycles that follow acceptance. Ready is high again in the cycle in which operand valid is high.
- R4: Register index all ones (31 by default) always supplies zero and counts toward neither bank.
- R5: If a slot's keep flag (bit 0 for slot A, bit 1 for B, bit 2 for C) is set, that slot's delivered value is kept. The next accepted instruction that names the same index in the same slot receives it without a bank read.
- R6: A reuse entry serves only its own slot. Every accepted instruction replaces all three entries, and a slot whose keep flag is clear becomes empty.
- R7: A write-back stores its data in the named register, except for the all-ones index. The new value is seen by instructions accepted in later cycles. An instruction accepted in the same cycle as the write reads the old value.
- R8: A write-back to the index held by a reuse entry empties that entry. This includes a write in the very cycle the entry is captured.
- R9: The same index named in two slots costs two reads of its bank, unless a slot hits its reuse entry.
- R10: An instruction presented while ready is low, or with valid low, is not accepted and produces no operand valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid_i | input | 1 | Instruction presented |
| iss_ready_o | output | 1 | Block can accept an instruction this cycle |
| src_a_i | input | 5 | Register index for slot A |
| src_b_i | input | 5 | Register index for slot B |
| src_c_i | input | 5 | Register index for slot C |
| keep_i | input | 3 | Per-slot keep flags, bit 0 = slot A |
| wb_en_i | input | 1 | Write-back strobe |
| wb_idx_i | input | 5 | Write-back register index |
| wb_data_i | input | 64 | Write-back data |
| opnd_valid_o | output | 1 | Operands valid, one-cycle pulse |
| opnd_a_o | output | 64 | Slot A operand |
| opnd_b_o | output | 64 | Slot B operand |
| opnd_c_o | output | 64 | Slot C operand |
| stall_o | output | 1 | Bank-conflict serialization in progress |

## Verification
The hardest case to reach is a reuse entry that must be dropped in exactly the cycle it is captured. This needs a write-back to the same index that lands on the accepting edge of an instruction that keeps that index. It is also hard to know whether a later hit was correctly refused when the latency alone would look the same. The stimulus draws indices from a small pool of low registers plus the zero index, so that conflicts, same-slot repeats and index collisions are frequent. It then fires random write-backs in the issue cycle itself. Directed cases cover pure one-bank triples, split triples, a wrong-slot repeat and an instruction held during a stall.

// File: rtl/operand_fetch_pkg.sv
package operand_fetch_pkg;
    localparam int NUM_SLOTS = 3;
    localparam int LAT_W     = 2;
    typedef logic [LAT_W-1:0] lat_t;
endpackage

// File: rtl/ofu_bank_rf.sv
module ofu_bank_rf
    import operand_fetch_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NUM_REGS = 32,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int ROWS    = NUM_REGS / 2,
    localparam int ROW_W   = $clog2(ROWS)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [IDX_W-1:0]                     wr_idx,
    input  logic [DATA_W-1:0]                    wr_data,
    input  logic [NUM_SLOTS-1:0][IDX_W-1:0]      rd_idx,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0]     rd_data
);
    localparam logic [IDX_W-1:0] ZERO_IDX = IDX_W'(NUM_REGS - 1);

    logic [NUM_SLOTS-1:0][DATA_W-1:0] bank_rd [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [DATA_W-1:0] mem_q [ROWS];
        logic [DATA_W-1:0] mem_d [ROWS];
        logic              hit_bank;

        assign hit_bank = wr_en && (wr_idx[0] == 1'(b)) && (wr_idx != ZERO_IDX);

        always_comb begin
            mem_d = mem_q;
            if (hit_bank) begin
                mem_d[wr_idx[IDX_W-1:1]] = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
            end else begin
                mem_q <= mem_d;
            end
        end

        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_port
            assign bank_rd[b][s] = mem_q[rd_idx[s][IDX_W-1:1]];
        end
    end

    always_comb begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
            rd_data[s] = bank_rd[rd_idx[s][0]][s];
        end
    end

    logic [ROW_W-1:0] unused_row;
    assign unused_row = '0;
endmodule

// File: rtl/ofu_conflict_count.sv
module ofu_conflict_count
    import operand_fetch_pkg::*;
#(
    parameter int IDX_W = 5,
    parameter logic [IDX_W-1:0] ZERO_IDX = '1
) (
    input  logic [NUM_SLOTS-1:0][IDX_W-1:0] idx,
    input  logic [NUM_SLOTS-1:0]            reuse_hit,
    output logic [NUM_SLOTS-1:0]            is_zero,
    output lat_t                            lat
);
    logic [NUM_SLOTS-1:0] need_read;
    lat_t cnt_even, cnt_odd, worst;

    always_comb begin
        cnt_even = '0;
        cnt_odd  = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            is_zero[s]   = (idx[s] == ZERO_IDX);
            need_read[s] = !is_zero[s] && !reuse_hit[s];
            if (need_read[s]) begin
                if (idx[s][0]) cnt_odd  = cnt_odd  + lat_t'(1);
                else           cnt_even = cnt_even + lat_t'(1);
            end
        end
        worst = (cnt_even > cnt_odd) ? cnt_even : cnt_odd;
        lat   = (worst == '0) ? lat_t'(1) : worst;
    end

    always_comb begin
        AST_LAT_BOUNDS: assert (lat >= lat_t'(1) && lat <= lat_t'(NUM_SLOTS)); // R2
    end
endmodule

// File: rtl/ofu_reuse_slot.sv
module ofu_reuse_slot #(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 5,
    parameter logic [IDX_W-1:0] ZERO_IDX = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              keep,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] value,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx,
    output logic              hit,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } entry_t;

    entry_t ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (capture) begin
            ent_d.valid = keep && (idx != ZERO_IDX) && !(wb_en && wb_idx == idx);
            ent_d.tag   = idx;
            ent_d.data  = value;
        end else if (wb_en && wb_idx == ent_q.tag) begin
            ent_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assign hit  = ent_q.valid && (ent_q.tag == idx);
    assign data = ent_q.data;

    AST_WB_DROPS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !capture && wb_idx == ent_q.tag) |=> !ent_q.valid); // R8
    AST_ZERO_NEVER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && idx == ZERO_IDX) |=> !ent_q.valid); // R4
endmodule

// File: rtl/operand_fetch.sv
module operand_fetch
    import operand_fetch_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NUM_REGS = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid_i,
    output logic              iss_ready_o,
    input  logic [IDX_W-1:0]  src_a_i,
    input  logic [IDX_W-1:0]  src_b_i,
    input  logic [IDX_W-1:0]  src_c_i,
    input  logic [2:0]        keep_i,
    input  logic              wb_en_i,
    input  logic [IDX_W-1:0]  wb_idx_i,
    input  logic [DATA_W-1:0] wb_data_i,
    output logic              opnd_valid_o,
    output logic [DATA_W-1:0] opnd_a_o,
    output logic [DATA_W-1:0] opnd_b_o,
    output logic [DATA_W-1:0] opnd_c_o,
    output logic              stall_o
);
    localparam logic [IDX_W-1:0] ZERO_IDX = IDX_W'(NUM_REGS - 1);

    typedef struct packed {
        logic                             busy;
        lat_t                             remain;
        logic                             out_valid;
        logic [NUM_SLOTS-1:0][DATA_W-1:0] opnd;
    } fetch_t;

    fetch_t st_d, st_q;

    logic [NUM_SLOTS-1:0][IDX_W-1:0]  src_idx;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] rf_val, ru_val, slot_val;
    logic [NUM_SLOTS-1:0]             ru_hit, is_zero;
    lat_t                             lat;
    logic                             accept;

    assign src_idx = {src_c_i, src_b_i, src_a_i};
    assign accept  = iss_valid_i && !st_q.busy;

    ofu_bank_rf #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) rf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wb_en_i),
        .wr_idx  (wb_idx_i),
        .wr_data (wb_data_i),
        .rd_idx  (src_idx),
        .rd_data (rf_val)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        ofu_reuse_slot #(.DATA_W(DATA_W), .IDX_W(IDX_W), .ZERO_IDX(ZERO_IDX)) reuse_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .capture (accept),
            .keep    (keep_i[s]),
            .idx     (src_idx[s]),
            .value   (slot_val[s]),
            .wb_en   (wb_en_i),
            .wb_idx  (wb_idx_i),
            .hit     (ru_hit[s]),
            .data    (ru_val[s])
        );
    end

    ofu_conflict_count #(.IDX_W(IDX_W), .ZERO_IDX(ZERO_IDX)) cnt_i (
        .idx       (src_idx),
        .reuse_hit (ru_hit),
        .is_zero   (is_zero),
        .lat       (lat)
    );

    always_comb begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (is_zero[s])     slot_val[s] = '0;
            else if (ru_hit[s]) slot_val[s] = ru_val[s];
            else                slot_val[s] = rf_val[s];
        end
    end

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = 1'b0;
        if (accept) begin
            st_d.opnd = slot_val;
            if (lat == lat_t'(1)) begin
                st_d.out_valid = 1'b1;
            end else begin
                st_d.busy   = 1'b1;
                st_d.remain = lat - lat_t'(1);
            end
        end else if (st_q.busy) begin
            if (st_q.remain == lat_t'(1)) begin
                st_d.busy      = 1'b0;
                st_d.out_valid = 1'b1;
            end else begin
                st_d.remain = st_q.remain - lat_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign iss_ready_o  = !st_q.busy;
    assign stall_o      = st_q.busy;
    assign opnd_valid_o = st_q.out_valid;
    assign opnd_a_o     = st_q.opnd[0];
    assign opnd_b_o     = st_q.opnd[1];
    assign opnd_c_o     = st_q.opnd[2];

    AST_SINGLE_CYCLE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lat == lat_t'(1)) |=> opnd_valid_o); // R2
    AST_CONFLICT_HOLDS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lat != lat_t'(1)) |=> (stall_o && !iss_ready_o && !opnd_valid_o)); // R3
    AST_STALL_ENDS_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall_o) |-> opnd_valid_o); // R3
    AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && src_a_i == ZERO_IDX) |=> (opnd_a_o == '0)); // R4
    AST_NO_ISSUE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (!iss_valid_i && !stall_o) |=> !opnd_valid_o); // R10
endmodule

// File: tb/operand_fetch_tb_top.sv
`timescale 1ns/1ps
module operand_fetch_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic        iss_ready;
    logic [4:0]  src_a = '0, src_b = '0, src_c = '0;
    logic [2:0]  keep = '0;
    logic        wb_en = 1'b0;
    logic [4:0]  wb_idx = '0;
    logic [63:0] wb_data = '0;
    logic        opnd_valid;
    logic [63:0] opnd_a, opnd_b, opnd_c;
    logic        stall;

    int total = 0;
    int bad   = 0;

    logic [63:0] m_reg [32];
    logic        m_rv  [3];
    logic [4:0]  m_tag [3];
    logic [63:0] m_dat [3];

    always #10 clk = ~clk;

    operand_fetch dut_i (
        .clk(clk), .rst_n(rst_n), .iss_valid_i(iss_valid), .iss_ready_o(iss_ready),
        .src_a_i(src_a), .src_b_i(src_b), .src_c_i(src_c), .keep_i(keep),
        .wb_en_i(wb_en), .wb_idx_i(wb_idx), .wb_data_i(wb_data),
        .opnd_valid_o(opnd_valid), .opnd_a_o(opnd_a), .opnd_b_o(opnd_b),
        .opnd_c_o(opnd_c), .stall_o(stall)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int exp_lat(input logic [4:0] ix [3], input logic hit [3]);
        int ce = 0, co = 0, w;
        for (int s = 0; s < 3; s++) begin
            if (ix[s] != 5'd31 && !hit[s]) begin
                if (ix[s][0]) co++; else ce++;
            end
        end
        w = (ce > co) ? ce : co;
        return (w == 0) ? 1 : w;
    endfunction

    task automatic do_wb(input logic [4:0] wi, input logic [63:0] wd);
        wb_en = 1'b1; wb_idx = wi; wb_data = wd;
        @(negedge clk);
        wb_en = 1'b0;
        if (wi != 5'd31) m_reg[wi] = wd;
        for (int s = 0; s < 3; s++) if (m_tag[s] == wi) m_rv[s] = 1'b0;
    endtask

    task automatic do_issue(input logic [4:0] a, input logic [4:0] b, input logic [4:0] c,
                            input logic [2:0] fl, input bit w, input logic [4:0] wi,
                            input logic [63:0] wd, input string req);
        logic [4:0]  ix [3];
        logic        hit [3];
        logic [63:0] ev [3];
        int lat_e, cyc;
        bit stall_ok;
        while (!iss_ready) @(negedge clk);
        ix[0] = a; ix[1] = b; ix[2] = c;
        for (int s = 0; s < 3; s++) begin
            hit[s] = m_rv[s] && (m_tag[s] == ix[s]);
            ev[s]  = (ix[s] == 5'd31) ? 64'd0 : (hit[s] ? m_dat[s] : m_reg[ix[s]]);
        end
        lat_e = exp_lat(ix, hit);
        iss_valid = 1'b1; src_a = a; src_b = b; src_c = c; keep = fl;
        wb_en = w; wb_idx = wi; wb_data = wd;
        @(negedge clk);
        iss_valid = 1'b0; wb_en = 1'b0;
        for (int s = 0; s < 3; s++) begin
            m_rv[s]  = fl[s] && (ix[s] != 5'd31) && !(w && wi == ix[s]);
            m_tag[s] = ix[s];
            m_dat[s] = ev[s];
        end
        if (w && wi != 5'd31) m_reg[wi] = wd;
        cyc = 1; stall_ok = 1'b1;
        while (!opnd_valid && cyc < 6) begin
            if (!stall || iss_ready) stall_ok = 1'b0;
            @(negedge clk);
            cyc++;
        end
        chk(cyc == lat_e, {req, " R2 latency"}, 64'(cyc), 64'(lat_e));
        chk(opnd_a == ev[0], {req, " R2 slot A"}, opnd_a, ev[0]);
        chk(opnd_b == ev[1], {req, " R2 slot B"}, opnd_b, ev[1]);
        chk(opnd_c == ev[2], {req, " R2 slot C"}, opnd_c, ev[2]);
        chk(iss_ready && stall_ok, {req, " R3 ready/stall"}, 64'({iss_ready, stall_ok}), 64'd3);
    endtask

    function automatic logic [4:0] pick();
        return ($urandom % 9 == 8) ? 5'd31 : 5'($urandom % 8);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        for (int s = 0; s < 3; s++) begin m_rv[s] = 1'b0; m_tag[s] = '0; m_dat[s] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(iss_ready && !opnd_valid && !stall, "R1 reset outputs",
            64'({iss_ready, opnd_valid, stall}), 64'b100);
        // R1 reuse entries empty and registers zero: same-slot repeat still conflicts
        do_issue(5'd0, 5'd2, 5'd4, 3'b000, 1'b0, 5'd0, 64'd0, "R1 empty after reset");

        for (int i = 0; i < 31; i++) do_wb(5'(i), 64'h1000_0000_0000_0000 + 64'(i * 17));

        do_issue(5'd0, 5'd2, 5'd4, 3'b000, 1'b0, 5'd0, 64'd0, "R2 all even");
        do_issue(5'd1, 5'd3, 5'd5, 3'b000, 1'b0, 5'd0, 64'd0, "R2 all odd");
        do_issue(5'd0, 5'd1, 5'd2, 3'b000, 1'b0, 5'd0, 64'd0, "R2 split");
        do_issue(5'd31, 5'd31, 5'd31, 3'b111, 1'b0, 5'd0, 64'd0, "R4 zero reg");
        do_issue(5'd31, 5'd2, 5'd4, 3'b000, 1'b0, 5'd0, 64'd0, "R4 zero plus even pair");
        do_issue(5'd2, 5'd2, 5'd3, 3'b000, 1'b0, 5'd0, 64'd0, "R9 duplicate index");
        do_issue(5'd0, 5'd2, 5'd4, 3'b111, 1'b0, 5'd0, 64'd0, "R5 prime");
        do_issue(5'd0, 5'd2, 5'd4, 3'b111, 1'b0, 5'd0, 64'd0, "R5 full hit");
        do_issue(5'd2, 5'd4, 5'd0, 3'b111, 1'b0, 5'd0, 64'd0, "R6 wrong slot");
        do_issue(5'd2, 5'd4, 5'd0, 3'b000, 1'b0, 5'd0, 64'd0, "R6 kept then dropped");
        do_issue(5'd2, 5'd4, 5'd0, 3'b000, 1'b0, 5'd0, 64'd0, "R6 flag clear empties");
        do_issue(5'd6, 5'd8, 5'd10, 3'b111, 1'b0, 5'd0, 64'd0, "R8 prime");
        do_wb(5'd8, 64'hDEAD_BEEF_0000_0008);
        do_issue(5'd6, 5'd8, 5'd10, 3'b111, 1'b0, 5'd0, 64'd0, "R8 write kills entry");
        do_issue(5'd12, 5'd14, 5'd16, 3'b111, 1'b1, 5'd14, 64'hABCD_0000_0000_0014, "R7 same-cycle write old value");
        do_issue(5'd12, 5'd14, 5'd16, 3'b111, 1'b0, 5'd0, 64'd0, "R8 same-cycle capture kill");
        do_issue(5'd14, 5'd1, 5'd3, 3'b000, 1'b0, 5'd0, 64'd0, "R7 later read new value");

        // R10: instruction held while stalled is not taken
        iss_valid = 1'b1; src_a = 5'd0; src_b = 5'd2; src_c = 5'd4; keep = 3'b000;
        @(negedge clk);
        src_a = 5'd1; src_b = 5'd3; src_c = 5'd5;
        for (int s = 0; s < 3; s++) begin m_rv[s] = 1'b0; m_tag[s] = 5'(2 * s); end
        @(negedge clk);
        @(negedge clk);
        chk(opnd_valid && opnd_a == m_reg[0], "R10 first instr delivered", opnd_a, m_reg[0]);
        iss_valid = 1'b0;
        @(negedge clk);
        chk(!opnd_valid && iss_ready, "R10 held instr ignored", 64'(opnd_valid), 64'd0);
        repeat (3) @(negedge clk);
        chk(!opnd_valid, "R10 idle no pulse", 64'(opnd_valid), 64'd0);

        for (int n = 0; n < 500; n++) begin
            if ($urandom % 6 == 0) do_wb(pick(), {$urandom, $urandom});
            do_issue(pick(), pick(), pick(), 3'($urandom % 8), ($urandom % 4 == 0),
                     pick(), {$urandom, $urandom}, "R5 R8 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule